// File: doc/BRIEF.md
# Register-Typed Packed SIMD Adder

This block adds or subtracts two 32-bit words as packed lanes. The opcode does not say how wide the lanes are or whether they are signed. The register numbers of the operands say this instead: each range of register indices belongs to a bank with a fixed lane width and signedness. The unit decodes the three register indices, checks that they fit together, and runs four, two or one lane operations in parallel. It produces a registered result one cycle later.

There are four operations: add, subtract, halving add and halving subtract. A two-bit mode field picks wrapping or saturating behaviour. A combination of registers or mode that is not allowed sets an illegal flag and forces the result to zero. A sticky flag records that some lane has clamped since reset. The block holds no register storage. The caller supplies the operand values along with the indices.

Top module: `regtyped_simd_adder`

## Requirements
- R1: After reset, `out_valid`, `illegal`, `sat_sticky` and `result` are all 0.
- R2: Each register index selects a bank. Indices 2..7 are signed 8-bit (four lanes) and 8..15 are unsigned 8-bit. Indices 16..23 are signed 16-bit (two lanes) and 24..29 are unsigned 16-bit. Indices 30..31 are one signed 32-bit element. Lane k occupies bits [k*W+W-1 : k*W]. The lane width and signedness come from the destination index.
- R3: `op` 0 adds and 1 subtracts (a minus b). With `mode` 0 these wrap modulo 2^W in each lane and never count as a clamp.
- R4: A wrapping add or subtract is legal when every non-zero index has the destination's lane width, even if signed and unsigned banks are mixed.
- R5: `mode` 1 with `op` 0 or 1 saturates. Signed lanes clamp to -2^(W-1) or 2^(W-1)-1. Unsigned lanes clamp to 0 or 2^W-1.
- R6: `op` 2 (halving add) and `op` 3 (halving subtract) return the low W bits of floor((a±b)/2), computed exactly. Signed banks use signed arithmetic and unsigned banks use unsigned arithmetic. These operations never clamp.
- R7: A source index of 0 contributes the value zero, whatever is on its operand bus. It takes part in no bank check.
- R8: The request is illegal in any of these cases: the destination index is 0 or 1; a source index is 1; `mode` is 2 or 3; `mode` is 1 with a halving op; or, for saturating and halving ops, a non-zero source is in a different bank from the destination. An illegal request sets `illegal` to 1 and `result` to 0.
- R9: `sat_sticky` becomes 1 in the cycle after a legal request in which any lane clamped. It stays 1 until reset.
- R10: `out_valid`, `result` and `illegal` update one clock after a cycle with `in_valid` high. With `in_valid` low, `out_valid` falls and `result` and `illegal` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present this cycle |
| op | input | 2 | 0 add, 1 sub, 2 halving add, 3 halving sub |
| mode | input | 2 | 0 wrapping, 1 saturating, 2..3 illegal |
| rd_idx | input | 5 | Destination register index |
| rs1_idx | input | 5 | First source register index |
| rs2_idx | input | 5 | Second source register index |
| opa | input | 32 | First source value |
| opb | input | 32 | Second source value |
| out_valid | output | 1 | Result registered for the last request |
| result | output | 32 | Packed lane results, zero when illegal |
| illegal | output | 1 | Last request was an illegal combination |
| sat_sticky | output | 1 | Some lane has clamped since reset |

## Verification
The bench builds the block with its default parameters: a 32-bit word, 8-bit narrow lanes and 16-bit middle lanes. These values cover every bank: four-lane signed and unsigned bytes, two-lane halfwords and the single 32-bit element. Requests reach both clamp bounds in each signedness, the floor behaviour of halving at negative odd differences, mixed-signedness wrapping, and each of the illegal combinations. A bench model of its own predicts every result in a scoreboard.

// File: rtl/simd_types_pkg.sv
package simd_types_pkg;

  localparam int IDX_W = 5;

  typedef enum logic [2:0] {
    BK_ZERO, BK_MASK, BK_S8, BK_U8, BK_S16, BK_U16, BK_S32
  } bank_e;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_SUB  = 2'd1,
    OP_HADD = 2'd2,
    OP_HSUB = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    LW_NARROW, LW_MID, LW_FULL, LW_NONE
  } width_e;

  // Bank boundaries are architectural: the index range carries the type.
  function automatic bank_e bank_of(input logic [IDX_W-1:0] idx);
    if (idx == 5'd0)       return BK_ZERO;
    else if (idx == 5'd1)  return BK_MASK;
    else if (idx <= 5'd7)  return BK_S8;
    else if (idx <= 5'd15) return BK_U8;
    else if (idx <= 5'd23) return BK_S16;
    else if (idx <= 5'd29) return BK_U16;
    else                   return BK_S32;
  endfunction

  function automatic width_e width_of(input bank_e b);
    case (b)
      BK_S8, BK_U8:   return LW_NARROW;
      BK_S16, BK_U16: return LW_MID;
      BK_S32:         return LW_FULL;
      default:        return LW_NONE;
    endcase
  endfunction

  function automatic logic is_signed_bank(input bank_e b);
    return (b == BK_S8) || (b == BK_S16) || (b == BK_S32);
  endfunction

endpackage

// File: rtl/simd_operand_decode.sv
module simd_operand_decode
  import simd_types_pkg::*;
(
  input  logic [1:0]       op,
  input  logic [1:0]       mode,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [IDX_W-1:0] rs1_idx,
  input  logic [IDX_W-1:0] rs2_idx,
  output logic             legal,
  output width_e           lane_w,
  output logic             lane_signed,
  output logic             do_sub,
  output logic             do_half,
  output logic             do_sat,
  output logic             rs1_zero,
  output logic             rs2_zero
);

  bank_e bd, b1, b2;
  logic  wrap_op, mode_ok, rd_ok, rs_ok, match1, match2;

  function automatic logic src_fits(input bank_e src, input bank_e dst,
                                    input logic width_only);
    if (src == BK_ZERO) return 1'b1;
    if (width_only)     return width_of(src) == width_of(dst);
    return src == dst;
  endfunction

  always_comb begin
    bd       = bank_of(rd_idx);
    b1       = bank_of(rs1_idx);
    b2       = bank_of(rs2_idx);
    do_half  = (op == OP_HADD) || (op == OP_HSUB);
    do_sub   = (op == OP_SUB)  || (op == OP_HSUB);
    do_sat   = (mode == 2'b01) && !do_half;
    wrap_op  = (mode == 2'b00) && !do_half;
    mode_ok  = (mode == 2'b00) || do_sat;
    rd_ok    = (bd != BK_ZERO) && (bd != BK_MASK);
    rs_ok    = (b1 != BK_MASK) && (b2 != BK_MASK);
    match1   = src_fits(b1, bd, wrap_op);
    match2   = src_fits(b2, bd, wrap_op);
    legal    = mode_ok && rd_ok && rs_ok && match1 && match2;
    lane_w      = width_of(bd);
    lane_signed = is_signed_bank(bd);
    rs1_zero = (b1 == BK_ZERO);
    rs2_zero = (b2 == BK_ZERO);
  end

endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu #(
  parameter int LW = 8
) (
  input  logic [LW-1:0] a,
  input  logic [LW-1:0] b,
  input  logic          sgn,
  input  logic          sub,
  input  logic          half,
  input  logic          sat,
  output logic [LW-1:0] y,
  output logic          clamp
);

  localparam int EW = LW + 2;
  localparam logic [LW-1:0] S_MIN = {1'b1, {(LW-1){1'b0}}};
  localparam logic [LW-1:0] S_MAX = {1'b0, {(LW-1){1'b1}}};

  // Exact sum or difference in two extra bits, then wrap, halve or clamp.
  function automatic logic [LW:0] lane_calc(
    input logic [LW-1:0] x, input logic [LW-1:0] z,
    input logic s, input logic dsub, input logic dhalf, input logic dsat);
    logic [EW-1:0] ex, ez, full;
    logic [LW-1:0] r;
    logic          c;
    ex = s ? {{2{x[LW-1]}}, x} : {2'b00, x};
    ez = s ? {{2{z[LW-1]}}, z} : {2'b00, z};
    full = dsub ? (ex - ez) : (ex + ez);
    r = full[LW-1:0];
    c = 1'b0;
    if (dhalf) begin
      r = full[LW:1];
    end else if (dsat) begin
      if (s) begin
        if (full[LW] != full[LW-1]) begin
          c = 1'b1;
          r = full[LW] ? S_MIN : S_MAX;
        end
      end else if (full[EW-1]) begin
        c = 1'b1;
        r = '0;
      end else if (full[LW]) begin
        c = 1'b1;
        r = '1;
      end
    end
    return {c, r};
  endfunction

  always_comb begin
    {clamp, y} = lane_calc(a, b, sgn, sub, half, sat);
  end

endmodule

// File: rtl/simd_lane_group.sv
module simd_lane_group #(
  parameter int DATA_W = 32,
  parameter int LW     = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sgn,
  input  logic              sub,
  input  logic              half,
  input  logic              sat,
  output logic [DATA_W-1:0] y,
  output logic              any_clamp
);

  localparam int N_LANES = DATA_W / LW;

  logic [N_LANES-1:0] clamps;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    simd_lane_alu #(.LW(LW)) u_alu (
      .a     (a[g*LW +: LW]),
      .b     (b[g*LW +: LW]),
      .sgn   (sgn),
      .sub   (sub),
      .half  (half),
      .sat   (sat),
      .y     (y[g*LW +: LW]),
      .clamp (clamps[g])
    );
  end

  assign any_clamp = |clamps;

endmodule

// File: rtl/regtyped_simd_adder.sv
module regtyped_simd_adder
  import simd_types_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 8,
  parameter int MID_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        op,
  input  logic [1:0]        mode,
  input  logic [4:0]        rd_idx,
  input  logic [4:0]        rs1_idx,
  input  logic [4:0]        rs2_idx,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              illegal,
  output logic              sat_sticky
);

  localparam int N_GROUPS = 3;
  localparam int GROUP_LW [N_GROUPS] = '{NARROW_W, MID_W, DATA_W};

  logic              dec_legal, dec_signed, dec_sub, dec_half, dec_sat;
  logic              rs1_zero, rs2_zero;
  width_e            dec_width;
  logic [DATA_W-1:0] src_a, src_b, sel_y;
  logic              sel_clamp;
  logic              sat_event;

  logic [DATA_W-1:0]   grp_y     [N_GROUPS];
  logic [N_GROUPS-1:0] grp_clamp;

  simd_operand_decode u_dec (
    .op          (op),
    .mode        (mode),
    .rd_idx      (rd_idx),
    .rs1_idx     (rs1_idx),
    .rs2_idx     (rs2_idx),
    .legal       (dec_legal),
    .lane_w      (dec_width),
    .lane_signed (dec_signed),
    .do_sub      (dec_sub),
    .do_half     (dec_half),
    .do_sat      (dec_sat),
    .rs1_zero    (rs1_zero),
    .rs2_zero    (rs2_zero)
  );

  assign src_a = rs1_zero ? '0 : opa;
  assign src_b = rs2_zero ? '0 : opb;

  for (genvar k = 0; k < N_GROUPS; k++) begin : g_group
    simd_lane_group #(.DATA_W(DATA_W), .LW(GROUP_LW[k])) u_grp (
      .a         (src_a),
      .b         (src_b),
      .sgn       (dec_signed),
      .sub       (dec_sub),
      .half      (dec_half),
      .sat       (dec_sat),
      .y         (grp_y[k]),
      .any_clamp (grp_clamp[k])
    );
  end

  always_comb begin
    sel_y     = '0;
    sel_clamp = 1'b0;
    case (dec_width)
      LW_NARROW: begin sel_y = grp_y[0]; sel_clamp = grp_clamp[0]; end
      LW_MID:    begin sel_y = grp_y[1]; sel_clamp = grp_clamp[1]; end
      LW_FULL:   begin sel_y = grp_y[2]; sel_clamp = grp_clamp[2]; end
      default:   begin sel_y = '0;       sel_clamp = 1'b0;         end
    endcase
  end

  // A lane clamp counts only for an accepted, legal request.
  assign sat_event = in_valid && dec_legal && sel_clamp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      result     <= '0;
      illegal    <= 1'b0;
      sat_sticky <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        illegal <= !dec_legal;
        result  <= dec_legal ? sel_y : '0;
      end
      if (sat_event) sat_sticky <= 1'b1;
    end
  end

endmodule

// File: rtl/simd_adder_checker.sv
module simd_adder_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        mode,
  input logic [4:0]        rd_idx,
  input logic [4:0]        rs1_idx,
  input logic [4:0]        rs2_idx,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              illegal,
  input logic              sat_sticky,
  input logic              sat_event
);

  p_illegal_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (result == '0));

  p_dest_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rd_idx < 5'd2) |=> illegal);

  p_src_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (rs1_idx == 5'd1 || rs2_idx == 5'd1)) |=> illegal);

  p_valid_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(illegal)));

  p_sticky_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sat_sticky |=> sat_sticky);

  p_sticky_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sat_event |=> sat_sticky);

  p_wrap_no_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b00) |-> !sat_event);

endmodule

bind regtyped_simd_adder simd_adder_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .mode       (mode),
  .rd_idx     (rd_idx),
  .rs1_idx    (rs1_idx),
  .rs2_idx    (rs2_idx),
  .out_valid  (out_valid),
  .result     (result),
  .illegal    (illegal),
  .sat_sticky (sat_sticky),
  .sat_event  (sat_event)
);

// File: tb/tb_regtyped_simd_adder.sv
module tb_regtyped_simd_adder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op = '0, mode = '0;
  logic [4:0]  rd_idx = '0, rs1_idx = '0, rs2_idx = '0;
  logic [31:0] opa = '0, opb = '0;
  logic        out_valid, illegal, sat_sticky;
  logic [31:0] result;

  always #2 clk = ~clk;  // 250 MHz

  regtyped_simd_adder dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .mode(mode),
    .rd_idx(rd_idx), .rs1_idx(rs1_idx), .rs2_idx(rs2_idx),
    .opa(opa), .opb(opb), .out_valid(out_valid), .result(result),
    .illegal(illegal), .sat_sticky(sat_sticky)
  );

  typedef struct {
    logic [31:0] res;
    bit          ill;
    bit          stk;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_errors = 0;
  bit   model_sticky = 0;
  bit   done = 0;

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // Bank code: 0 zero, 1 mask, 2 s8, 3 u8, 4 s16, 5 u16, 6 s32
  function automatic int bank(input int i);
    if (i == 0) return 0;
    if (i == 1) return 1;
    if (i <= 7) return 2;
    if (i <= 15) return 3;
    if (i <= 23) return 4;
    if (i <= 29) return 5;
    return 6;
  endfunction

  function automatic int wclass(input int bk);
    return (bk <= 3) ? 8 : (bk <= 5) ? 16 : 32;
  endfunction

  function automatic void model(input int o, input int m, input int rd,
      input int r1, input int r2, input logic [31:0] a, input logic [31:0] b,
      output logic [31:0] y, output bit ill, output bit clamp);
    int bd, b1, b2, w;
    bit half, sub, wrap, sg;
    longint av, bv, acc, msk;
    bd = bank(rd); b1 = bank(r1); b2 = bank(r2);
    half = (o >= 2); sub = (o % 2) == 1; wrap = (m == 0) && !half;
    ill = 0; clamp = 0; y = '0;
    if (m > 1 || (half && m != 0)) ill = 1;
    if (bd < 2 || b1 == 1 || b2 == 1) ill = 1;
    if (b1 != 0 && (wrap ? wclass(b1) != wclass(bd) : b1 != bd)) ill = 1;
    if (b2 != 0 && (wrap ? wclass(b2) != wclass(bd) : b2 != bd)) ill = 1;
    if (ill) return;
    w  = wclass(bd);
    sg = (bd == 2 || bd == 4 || bd == 6);
    av = (r1 == 0) ? 0 : longint'({32'd0, a});
    bv = (r2 == 0) ? 0 : longint'({32'd0, b});
    msk = (64'sd1 <<< w) - 1;
    acc = 0;
    for (int l = 0; l < 32 / w; l++) begin
      longint x, z, f, lo, hi;
      x = (av >>> (l * w)) & msk;
      z = (bv >>> (l * w)) & msk;
      if (sg && x[w-1]) x = x - (64'sd1 <<< w);
      if (sg && z[w-1]) z = z - (64'sd1 <<< w);
      f = sub ? x - z : x + z;
      if (half) f = f >>> 1;
      else if (m == 1) begin
        lo = sg ? -(64'sd1 <<< (w - 1)) : 0;
        hi = sg ? (64'sd1 <<< (w - 1)) - 1 : msk;
        if (f < lo) begin f = lo; clamp = 1; end
        if (f > hi) begin f = hi; clamp = 1; end
      end
      acc = acc | ((f & msk) <<< (l * w));
    end
    y = acc[31:0];
  endfunction

  // Driver: one request per call, expected item pushed at the same time.
  task automatic send(input string tag, input int o, input int m,
      input int rd, input int r1, input int r2,
      input logic [31:0] a, input logic [31:0] b);
    exp_t e;
    bit   c;
    model(o, m, rd, r1, r2, a, b, e.res, e.ill, c);
    if (c) model_sticky = 1;
    e.stk = model_sticky;
    e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    in_valid = 1'b1; op = o[1:0]; mode = m[1:0];
    rd_idx = rd[4:0]; rs1_idx = r1[4:0]; rs2_idx = r2[4:0];
    opa = a; opb = b;
    @(negedge clk);
    in_valid = 1'b0;
    opa = 32'hDEAD_BEEF; opb = 32'h1234_5678;
  endtask

  // Monitor: compares each registered result against the queue head.
  always @(negedge clk) begin
    if (rst_n && out_valid && !done) begin
      if (exp_q.size() == 0) begin
        check("R10 unexpected out_valid", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.tag, " result"}, result, e.res);
        check({e.tag, " illegal (R8)"}, {31'd0, illegal}, {31'd0, e.ill});
        check({e.tag, " sticky (R9)"}, {31'd0, sat_sticky}, {31'd0, e.stk});
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    #400000;
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 result", result, 32'd0);
    check("R1 illegal", {31'd0, illegal}, 32'd0);
    check("R1 sat_sticky", {31'd0, sat_sticky}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Wrapping, each bank (R2, R3) - no clamps yet
    send("R2 R3 s8 wrap add", 0, 0, 2, 3, 4, 32'h7F01_FF80, 32'h0101_0180);
    send("R2 R3 u8 wrap sub", 1, 0, 8, 9, 15, 32'h0010_FF00, 32'h0120_0101);
    send("R2 R3 s16 wrap sub", 1, 0, 16, 17, 23, 32'h8000_0001, 32'h0001_0002);
    send("R2 R3 u16 wrap add", 0, 0, 24, 25, 29, 32'hFFFF_1234, 32'h0001_1111);
    send("R2 R3 s32 wrap add", 0, 0, 30, 31, 30, 32'h7FFF_FFFF, 32'h0000_0001);
    // Mixed signedness, same width (R4)
    send("R4 mixed 8 wrap", 0, 0, 2, 8, 15, 32'h1122_3344, 32'hF0F0_F0F0);
    send("R4 mixed 16 wrap", 1, 0, 24, 16, 25, 32'h0000_8000, 32'h0001_0001);
    // Halving (R6)
    send("R6 s8 hadd neg", 2, 0, 5, 6, 7, 32'h80FF_7F03, 32'h80FE_7F00);
    send("R6 u8 hadd", 2, 0, 10, 11, 12, 32'hFFFF_0103, 32'hFFFE_0100);
    send("R6 u16 hsub neg", 3, 0, 26, 27, 28, 32'h0000_0005, 32'h0003_0002);
    send("R6 s16 hsub", 3, 0, 18, 19, 20, 32'h8000_7FFF, 32'h7FFF_8000);
    send("R6 s32 hsub odd", 3, 0, 31, 30, 31, 32'hFFFF_FFFD, 32'h0000_0000);
    // Source index 0 reads zero (R7)
    send("R7 rs2 zero", 0, 0, 2, 3, 0, 32'h0102_0304, 32'hFFFF_FFFF);
    send("R7 rs1 zero sub", 1, 0, 16, 0, 17, 32'hFFFF_FFFF, 32'h0001_0002);
    // Illegal combinations (R8)
    send("R8 rd is 0", 0, 0, 0, 2, 3, 32'h1, 32'h1);
    send("R8 rd is 1", 0, 0, 1, 2, 3, 32'h1, 32'h1);
    send("R8 rs is mask", 0, 0, 2, 1, 3, 32'h1, 32'h1);
    send("R8 width mismatch", 0, 0, 2, 16, 3, 32'h1, 32'h1);
    send("R8 sat sign mismatch", 0, 1, 2, 8, 3, 32'h1, 32'h1);
    send("R8 half sign mismatch", 2, 0, 24, 16, 24, 32'h1, 32'h1);
    send("R8 mode 2", 0, 2, 2, 3, 4, 32'h1, 32'h1);
    send("R8 half with sat", 2, 1, 2, 3, 4, 32'h1, 32'h1);

    // Idle gap: out_valid drops, result holds (R10)
    repeat (3) @(negedge clk);
    check("R10 out_valid idle", {31'd0, out_valid}, 32'd0);
    check("R10 result held", result, 32'd0);
    check("R10 queue drained", exp_q.size(), 32'd0);

    // Saturation without clamp keeps sticky low (R5, R9)
    send("R5 s8 sat no clamp", 0, 1, 3, 4, 5, 32'h0102_0304, 32'h0101_0101);
    // Saturation with clamps
    send("R5 R9 u8 sat add high", 0, 1, 8, 9, 10, 32'hFF80_0001, 32'h0180_0001);
    send("R5 u8 sat sub low", 1, 1, 8, 9, 10, 32'h0000_0510, 32'h0100_0620);
    send("R5 s8 sat both", 0, 1, 2, 3, 4, 32'h7F80_4010, 32'h01FF_4010);
    send("R5 s16 sat sub", 1, 1, 16, 17, 18, 32'h8000_7FFF, 32'h0001_FFFF);
    send("R5 u16 sat sub", 1, 1, 24, 25, 26, 32'h0001_FFFF, 32'h0002_0001);
    send("R5 s32 sat add", 0, 1, 30, 31, 30, 32'h7FFF_FFFF, 32'h0000_0001);
    send("R5 s32 sat sub", 1, 1, 30, 31, 30, 32'h8000_0000, 32'h0000_0001);
    // Sticky stays after a clean op (R9)
    send("R9 sticky holds", 0, 0, 2, 3, 4, 32'h0, 32'h0);

    repeat (4) @(negedge clk);
    check("R10 final drain", exp_q.size(), 32'd0);
    check("R9 sticky final", {31'd0, sat_sticky}, 32'd1);
    finish_run();
  end

endmodule